// File: doc/BRIEF.md
# Block-Transfer DMA Sequencer

This block fetches data from host memory in fixed 16-byte blocks on behalf of an on-chip consumer. Software programs a start address and a block count, sets a start flag, and then polls a control/status word until the engine has finished or has flagged an error. Each block is requested with a single read request on a plain request/acknowledge master port; the engine keeps the remaining count and the current address in its registers and advances them after every completed block.

The count is held as blocks-minus-one in a 12-bit field and decremented in place. When the block whose count field is already zero completes, the whole control word clears itself, start flag included, and a one-cycle completion pulse is raised. A single 64-bit write can load the control word (low half) and the start address (high half) together. The sequencer has three states: `SEQ_IDLE` (no transfer), `SEQ_LAUNCH` (alignment check before each block) and `SEQ_REQ` (block request outstanding). Transitions: `SEQ_IDLE -> SEQ_LAUNCH` on an accepted start write; `SEQ_LAUNCH -> SEQ_REQ` when the address is aligned; `SEQ_LAUNCH -> SEQ_IDLE` on a misaligned address or an abort; `SEQ_REQ -> SEQ_LAUNCH` on acknowledge with blocks left; `SEQ_REQ -> SEQ_IDLE` on acknowledge of the last block, on a bus error, or on an abort.

Top module: `dma_blk_engine`

## Requirements
- R1: After reset the control word and the address register both read zero, no request is raised and the completion pulse is low.
- R2: The control word reads start at bit 31, busy at bit 30, error at bit 29 and the blocks-minus-one count at bits 11:0; every other bit reads zero. Register select 0 is the control word and 1 is the address register.
- R3: A write with `reg_wide` set loads the control word from `reg_wdata[31:0]` and the address register from `reg_wdata[63:32]` in the same cycle.
- R4: An accepted control write with bit 31 set starts a transfer; the request is raised from the second clock edge after the write edge, carrying the current address.
- R5: Busy reads one exactly while a block request is outstanding, and an outstanding request holds its address until it is answered.
- R6: When a block is acknowledged with a non-zero count, the count drops by one and the address grows by 16; the next request follows after one idle cycle, so a count field of N yields N+1 requests (up to 4096).
- R7: When the block with count zero is acknowledged, the whole control word reads zero from the next cycle, the address keeps the last block's address, and `done_pulse` is high for exactly that one cycle.
- R8: A bus error response sets error, clears start and busy, freezes count and address, and no further request is raised.
- R9: A start with address bits 3:0 not all zero sets error and clears start without raising any request.
- R10: While a transfer is active, writes to the address register and non-zero control writes have no effect.
- R11: A control write of value zero while a transfer is active clears the control word, drops any request, keeps the address, and gives no completion pulse.
- R12: An accepted control write while idle replaces the count and start flag and clears a previous error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 64-bit write: control in low half, address in high half |
| reg_sel | input | 1 | Write target for 32-bit writes (0 control, 1 address) |
| reg_wdata | input | 64 | Write data |
| reg_rd_sel | input | 1 | Read select (0 control, 1 address) |
| reg_rdata | output | 32 | Read data, combinational |
| mreq_valid | output | 1 | Block read request outstanding |
| mreq_addr | output | 32 | Byte address of the requested block |
| mreq_ack | input | 1 | Block read completed |
| mreq_err | input | 1 | Block read failed with a bus error |
| done_pulse | output | 1 | One-cycle pulse when the last block completes |

## Verification
A wrong sequencer state or a stale count shows at the ports within one or two cycles: the request line rises or falls on the wrong edge, the busy bit disagrees with the request line, or the address on the request port differs from the expected block address. Because a reference model predicts request, address, both register readbacks and the completion pulse every cycle, a bad decrement or a missed self-clear is reported on the first block where it diverges rather than only at the end of a transfer. Error capture and abort are checked by reading the frozen count and address back through the register port right after the event.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;

    localparam int CTRL_START_BIT = 31;
    localparam int CTRL_BUSY_BIT  = 30;
    localparam int CTRL_ERR_BIT   = 29;
    localparam int REG_DATA_W     = 32;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LAUNCH = 2'd1,
        SEQ_REQ    = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic adv;       // block acknowledged, more remain
        logic fin;       // last block acknowledged
        logic fault;     // bus error response
        logic misalign;  // start address not block aligned
    } seq_ev_t;

endpackage

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
    import dma_blk_pkg::*;
#(
    parameter int BLK_BYTES = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              go,
    input  logic                              abort,
    input  logic [$clog2(BLK_BYTES)-1:0]      addr_ofs,
    input  logic                              cnt_zero,
    input  logic                              mreq_ack,
    input  logic                              mreq_err,
    output logic                              busy,
    output logic                              mreq_valid,
    output seq_ev_t                           ev,
    output logic                              done_pulse
);

    localparam int OFS_W = $clog2(BLK_BYTES);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       aligned;
    logic       done_q;

    assign aligned = (addr_ofs == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (go) state_d = SEQ_LAUNCH;
            end
            SEQ_LAUNCH: begin
                if (abort || !aligned) state_d = SEQ_IDLE;
                else                   state_d = SEQ_REQ;
            end
            SEQ_REQ: begin
                if (abort || mreq_err)  state_d = SEQ_IDLE;
                else if (mreq_ack)      state_d = cnt_zero ? SEQ_IDLE : SEQ_LAUNCH;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == SEQ_REQ) && !abort && !mreq_err
                       && mreq_ack && cnt_zero;
        end
    end

    // outputs
    always_comb begin
        ev         = '0;
        mreq_valid = 1'b0;
        busy       = 1'b0;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_LAUNCH: begin
                ev.misalign = !abort && !aligned;
            end
            SEQ_REQ: begin
                mreq_valid = 1'b1;
                busy       = 1'b1;
                ev.fault   = !abort && mreq_err;
                ev.fin     = !abort && !mreq_err && mreq_ack && cnt_zero;
                ev.adv     = !abort && !mreq_err && mreq_ack && !cnt_zero;
            end
            default: ;
        endcase
    end

    assign done_pulse = done_q;

    // an unanswered request stays up (R5)
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ack && !mreq_err && !abort) |=> mreq_valid);

    // aligned launch leads to a request on the next edge (R4)
    p_launch_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_LAUNCH && aligned && !abort) |=> mreq_valid);

    // completion pulse lasts one cycle (R7)
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // misaligned start never reaches a request (R9)
    p_misalign_norq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev.misalign |=> !mreq_valid);

    logic unused_ofs;
    assign unused_ofs = ^addr_ofs[OFS_W-1:0];

endmodule

// File: rtl/dma_blk_regfile.sv
module dma_blk_regfile
    import dma_blk_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int BLK_BYTES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_wide,
    input  logic                          reg_sel,
    input  logic [2*REG_DATA_W-1:0]       reg_wdata,
    input  logic                          reg_rd_sel,
    output logic [REG_DATA_W-1:0]         reg_rdata,
    input  logic                          seq_busy,
    input  seq_ev_t                       ev,
    output logic                          go,
    output logic                          abort,
    output logic                          active,
    output logic [REG_DATA_W-1:0]         addr_q,
    output logic                          cnt_zero
);

    localparam int PAD_W = CTRL_ERR_BIT - CNT_W;
    localparam logic [REG_DATA_W-1:0] BLK_STEP = REG_DATA_W'(BLK_BYTES);

    logic                  start_q;
    logic                  err_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  wr_ctrl;
    logic                  wr_addr;
    logic [REG_DATA_W-1:0] ctrl_wd;
    logic [REG_DATA_W-1:0] addr_wd;

    assign ctrl_wd = reg_wdata[REG_DATA_W-1:0];
    assign addr_wd = reg_wide ? reg_wdata[2*REG_DATA_W-1:REG_DATA_W]
                              : reg_wdata[REG_DATA_W-1:0];
    assign wr_ctrl = reg_wr && (reg_wide || !reg_sel);
    assign wr_addr = reg_wr && (reg_wide ||  reg_sel);

    assign active   = start_q;
    assign abort    = start_q && wr_ctrl && (ctrl_wd == '0);
    assign go       = !start_q && wr_ctrl && ctrl_wd[CTRL_START_BIT];
    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
            addr_q  <= '0;
        end else if (abort) begin
            start_q <= 1'b0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
        end else if (!start_q) begin
            if (wr_ctrl) begin
                start_q <= ctrl_wd[CTRL_START_BIT];
                err_q   <= 1'b0;
                cnt_q   <= ctrl_wd[CNT_W-1:0];
            end
            if (wr_addr) addr_q <= addr_wd;
        end else begin
            if (ev.fault || ev.misalign) begin
                start_q <= 1'b0;
                err_q   <= 1'b1;
            end else if (ev.fin) begin
                start_q <= 1'b0;
                err_q   <= 1'b0;
                cnt_q   <= '0;
            end else if (ev.adv) begin
                cnt_q   <= cnt_q - 1'b1;
                addr_q  <= addr_q + BLK_STEP;
            end
        end
    end

    always_comb begin
        if (reg_rd_sel) reg_rdata = addr_q;
        else            reg_rdata = {start_q, seq_busy, err_q, {PAD_W{1'b0}}, cnt_q};
    end

    // error capture freezes state (R8)
    p_fault_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev.fault |=> (err_q && !start_q && $stable(cnt_q) && $stable(addr_q)));

    // per-block step (R6)
    p_adv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev.adv |=> (addr_q == $past(addr_q) + BLK_STEP) && (cnt_q == $past(cnt_q) - 1'b1));

    // abort clears control, keeps address (R11)
    p_abort_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!start_q && !err_q && cnt_q == '0 && $stable(addr_q)));

    // busy only inside an active transfer (R5)
    p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> start_q);

    // address untouched while active except by the sequencer (R10)
    p_addr_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && !ev.adv) |=> $stable(addr_q));

endmodule

// File: rtl/dma_blk_engine.sv
module dma_blk_engine
    import dma_blk_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int BLK_BYTES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic                      reg_wide,
    input  logic                      reg_sel,
    input  logic [63:0]               reg_wdata,
    input  logic                      reg_rd_sel,
    output logic [31:0]               reg_rdata,
    output logic                      mreq_valid,
    output logic [31:0]               mreq_addr,
    input  logic                      mreq_ack,
    input  logic                      mreq_err,
    output logic                      done_pulse
);

    localparam int OFS_W = $clog2(BLK_BYTES);

    logic            go;
    logic            abort;
    logic            active;
    logic            busy;
    logic            cnt_zero;
    logic [31:0]     addr_q;
    seq_ev_t         ev;

    dma_blk_regfile #(
        .CNT_W     (CNT_W),
        .BLK_BYTES (BLK_BYTES)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wide   (reg_wide),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rd_sel (reg_rd_sel),
        .reg_rdata  (reg_rdata),
        .seq_busy   (busy),
        .ev         (ev),
        .go         (go),
        .abort      (abort),
        .active     (active),
        .addr_q     (addr_q),
        .cnt_zero   (cnt_zero)
    );

    dma_blk_seq #(
        .BLK_BYTES (BLK_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .abort      (abort),
        .addr_ofs   (addr_q[OFS_W-1:0]),
        .cnt_zero   (cnt_zero),
        .mreq_ack   (mreq_ack),
        .mreq_err   (mreq_err),
        .busy       (busy),
        .mreq_valid (mreq_valid),
        .ev         (ev),
        .done_pulse (done_pulse)
    );

    assign mreq_addr = addr_q;

    // every issued request is block aligned (R9)
    p_req_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> (mreq_addr[OFS_W-1:0] == '0));

    // a request only exists inside an active transfer (R4)
    p_req_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> active);

    // self-clear at completion (R7)
    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!active && !mreq_valid));

endmodule

// File: tb/dma_blk_engine_bench.sv
module dma_blk_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_wide = 1'b0, reg_sel = 1'b0, reg_rd_sel = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mreq_valid;
    logic [31:0] mreq_addr;
    logic        mreq_ack = 1'b0, mreq_err = 1'b0;
    logic        done_pulse;

    always #4 clk = ~clk;

    dma_blk_engine u_dma_blk_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rd_sel(reg_rd_sel),
        .reg_rdata(reg_rdata), .mreq_valid(mreq_valid), .mreq_addr(mreq_addr),
        .mreq_ack(mreq_ack), .mreq_err(mreq_err), .done_pulse(done_pulse)
    );

    int checks = 0, fails = 0;
    int cycles = 0;
    int reqs = 0, dones = 0;
    bit prev_valid = 0;
    bit hold_sel = 0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // behavioural reference model
    bit        m_start, m_err, m_done;
    bit [11:0] m_cnt;
    bit [31:0] m_addr;
    int        m_phase; // 0 idle, 1 check, 2 waiting answer

    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 0; m_err = 0; m_done = 0; m_cnt = 0; m_addr = 0; m_phase = 0;
        end else begin
            bit wc, wa;
            bit [31:0] cv, av;
            wc = reg_wr && (reg_wide || !reg_sel);
            wa = reg_wr && (reg_wide || reg_sel);
            cv = reg_wdata[31:0];
            av = reg_wide ? reg_wdata[63:32] : reg_wdata[31:0];
            m_done = 0;
            if (m_start && wc && cv == 0) begin
                m_start = 0; m_err = 0; m_cnt = 0; m_phase = 0;
            end else if (!m_start) begin
                if (wc) begin
                    m_start = cv[31]; m_err = 0; m_cnt = cv[11:0];
                    m_phase = cv[31] ? 1 : 0;
                end
                if (wa) m_addr = av;
            end else if (m_phase == 1) begin
                if (m_addr % 16 != 0) begin m_err = 1; m_start = 0; m_phase = 0; end
                else m_phase = 2;
            end else if (m_phase == 2) begin
                if (mreq_err) begin m_err = 1; m_start = 0; m_phase = 0; end
                else if (mreq_ack) begin
                    if (m_cnt == 0) begin m_start = 0; m_phase = 0; m_done = 1; end
                    else begin m_cnt = m_cnt - 1; m_addr = m_addr + 16; m_phase = 1; end
                end
            end
        end
    end

    // per-cycle comparison
    always @(posedge clk) begin
        #2;
        cycles++;
        if (rst_n) begin
            bit [31:0] ectl;
            ectl = {m_start, m_phase == 2, m_err, 17'd0, m_cnt};
            chk("R4 request line", mreq_valid, m_phase == 2);
            if (m_phase == 2) chk("R5 request address", mreq_addr, m_addr);
            if (reg_rd_sel == 0) chk("R2 control readback", reg_rdata, ectl);
            else                 chk("R3 address readback", reg_rdata, m_addr);
            chk("R7 completion pulse", done_pulse, m_done);
            if (mreq_valid && !prev_valid) reqs++;
            if (done_pulse) dones++;
            prev_valid = mreq_valid;
            if (!hold_sel) reg_rd_sel = ~reg_rd_sel;
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // bus responder
    int ack_lat = 0, err_at = -1, blk_idx = 0, wcnt = 0;
    bit resp_sent = 0;
    always @(negedge clk) begin
        mreq_ack = 0; mreq_err = 0;
        if (mreq_valid && !resp_sent) begin
            if (wcnt >= ack_lat) begin
                if (blk_idx == err_at) mreq_err = 1; else mreq_ack = 1;
                blk_idx++; wcnt = 0; resp_sent = 1;
            end else wcnt++;
        end else if (!mreq_valid) begin
            wcnt = 0; resp_sent = 0;
        end
    end

    task automatic wr32(input bit sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_wide = 0; reg_sel = sel; reg_wdata = {32'h0, d};
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic wr64(input logic [31:0] ctl, input logic [31:0] adr);
        @(negedge clk);
        reg_wr = 1; reg_wide = 1; reg_sel = 0; reg_wdata = {adr, ctl};
        @(negedge clk);
        reg_wr = 0; reg_wide = 0;
    endtask

    task automatic rd(input bit sel, output logic [31:0] d);
        @(negedge clk);
        hold_sel = 1; reg_rd_sel = sel;
        #1 d = reg_rdata;
        hold_sel = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && (m_start || m_phase != 0); i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic setup(input int lat, input int ea);
        ack_lat = lat; err_at = ea; blk_idx = 0;
    endtask

    initial begin
        logic [31:0] v;
        int r0, d0;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(0, v); chk("R1 control after reset", v, 32'h0);
        rd(1, v); chk("R1 address after reset", v, 32'h0);
        chk("R1 no request in reset", mreq_valid, 0);
        chk("R1 no pulse in reset", done_pulse, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        rd(0, v); chk("R1 control after release", v, 32'h0);

        // R4 R6 R7: three blocks, 32-bit writes, immediate answers
        setup(0, -1); r0 = reqs; d0 = dones;
        wr32(1, 32'h1000_0000);
        wr32(0, 32'h8000_0002);
        wait_idle();
        chk("R6 three requests", reqs - r0, 3);
        chk("R7 one pulse", dones - d0, 1);
        rd(1, v); chk("R7 address holds last block", v, 32'h1000_0020);
        rd(0, v); chk("R7 control self-cleared", v, 32'h0);

        // R3 wide write, single block, slow answer
        setup(2, -1); r0 = reqs;
        wr64(32'h8000_0000, 32'h2000_0040);
        rd(1, v); chk("R3 address from high half", v, 32'h2000_0040);
        wait_idle();
        chk("R3 one request", reqs - r0, 1);

        // R8 bus error on second of four blocks
        setup(1, 1); r0 = reqs;
        wr64(32'h8000_0003, 32'h5000_0000);
        wait_idle();
        rd(0, v); chk("R8 error captured, count frozen", v, 32'h2000_0002);
        rd(1, v); chk("R8 address frozen", v, 32'h5000_0010);
        chk("R8 two requests then stop", reqs - r0, 2);

        // R12 idle control write clears error
        wr32(0, 32'h0000_0005);
        rd(0, v); chk("R12 error cleared, count replaced", v, 32'h0000_0005);

        // R9 misaligned start
        setup(0, -1); r0 = reqs;
        wr64(32'h8000_0001, 32'h3000_0008);
        wait_idle();
        rd(0, v); chk("R9 misalign error", v, 32'h2000_0001);
        chk("R9 no request", reqs - r0, 0);

        // R10 writes during transfer ignored
        setup(20, -1); r0 = reqs;
        wr64(32'h8000_0007, 32'h6000_0000);
        for (int i = 0; i < 10 && !mreq_valid; i++) @(negedge clk);
        wr32(1, 32'hDEAD_0000);
        wr32(0, 32'h8000_0003);
        rd(1, v); chk("R10 address write ignored", v, 32'h6000_0000);
        rd(0, v); chk("R10 control write ignored", v[11:0], 12'h007);
        setup(0, -1);
        wait_idle();
        chk("R10 eight requests", reqs - r0, 8);

        // R11 abort
        setup(30, -1); d0 = dones;
        wr64(32'h8000_0009, 32'h7000_0000);
        for (int i = 0; i < 10 && !mreq_valid; i++) @(negedge clk);
        wr32(0, 32'h0);
        rd(0, v); chk("R11 control cleared", v, 32'h0);
        chk("R11 request dropped", mreq_valid, 0);
        rd(1, v); chk("R11 address kept", v, 32'h7000_0000);
        repeat (40) @(negedge clk);
        chk("R11 no pulse", dones - d0, 0);

        // R6 R7 full 4096 blocks
        setup(0, -1); r0 = reqs; d0 = dones;
        wr64(32'h8000_0FFF, 32'h4000_0000);
        wait_idle();
        chk("R6 4096 requests", reqs - r0, 4096);
        rd(1, v); chk("R7 final address at 4096", v, 32'h4000_FFF0);
        chk("R7 single pulse at 4096", dones - d0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule